// File: doc/BRIEF.md
# Two-Channel PWM Action Qualifier with Shadowed Software Force

This block is the output stage of a PWM generator. It turns the event strobes of a time base (counter at zero, counter at period, counter equal to compare A while counting up, counter equal to compare B while counting up) into the levels of two output pins. Each channel has its own control word. In that word, every event owns a 2-bit action field that can leave the pin alone, clear it, set it or toggle it. Events count only on a cycle where the prescaled time-base tick is high, and the pins are registered, so they change at that clock edge.

Software can hold either pin at a fixed level with a continuous force setting. The setting is written into a shadow register and reaches the active force register at a selectable reload point. That point can be a zero event, a period event, either of the two, or every tick, which is the immediate mode. While an active force holds a level, it overrides every event action on that channel. The counter that produces the events lies outside this block, and so do dead-band, chopping and trip handling.

Top module: `pwm_aq_dual`

## Requirements
- R1: While rst is high, and after it is released with no further stimulus, out_a and out_b are low and the active and shadow force settings hold "no force" for both channels.
- R2: A channel's control word holds four 2-bit action fields: zero event in bits 1:0, period event in bits 3:2, compare-A-up event in bits 5:4, compare-B-up event in bits 9:8. The action codes are 00 = no change, 01 = drive low, 10 = drive high, 11 = toggle.
- R3: Event strobes and their actions take effect only in a cycle where tick is high. Strobes with tick low leave both outputs unchanged.
- R4: When several events arrive on one tick, the winning action comes from the highest-priority event whose field is not 00. The order is compare-B-up first, then compare-A-up, then period, then zero.
- R5: The outputs are registered. A tick sampled at a rising clock edge changes the pins at that edge and not before it.
- R6: The force value frc_val holds channel A in bits 1:0 and channel B in bits 3:2, coded 00 or 11 = no force, 01 = force low, 10 = force high. On each tick, an effective force of low or high drives that level and overrides all event actions of that channel.
- R7: A high frc_wr copies frc_val into the shadow at that edge. A shadow value does not touch the outputs until it has been reloaded into the active register.
- R8: frc_reload selects the reload point: 00 = tick with a zero event, 01 = tick with a period event, 10 = tick with either event. On a reloading tick, the freshly loaded force already governs the output of that same tick.
- R9: frc_reload = 11 (immediate) reloads the shadow on every tick. A written force therefore controls the pins from the next tick after the write.
- R10: With a control word of zero = high, period = high and compare-up = low (normal polarity), the pin is high from zero until the compare match. The opposite levels (inverted polarity) give the complementary waveform.
- R11: The two channels are independent. The control word and force field of one channel do not affect the other pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Prescaled time-base tick qualifying events |
| evt_zero | input | 1 | Counter-at-zero event strobe |
| evt_period | input | 1 | Counter-at-period event strobe |
| evt_cmpa_up | input | 1 | Compare A match while counting up |
| evt_cmpb_up | input | 1 | Compare B match while counting up |
| ctl_a | input | CTRL_W | Action control word, channel A |
| ctl_b | input | CTRL_W | Action control word, channel B |
| frc_wr | input | 1 | Write strobe for the force shadow |
| frc_val | input | 4 | Force settings, A in 1:0, B in 3:2 |
| frc_reload | input | 2 | Reload point of the force shadow |
| out_a | output | 1 | PWM pin, channel A |
| out_b | output | 1 | PWM pin, channel B |

## Verification
Directed patterns come first. A normal-polarity and an inverted-polarity cycle over zero, compare and period tell correct field positions apart from swapped ones. Toggle sequences separate the toggle code from set and clear. Stacked events with chosen field values expose any wrong priority order, including the case where a higher event with action 00 must yield to a lower one. Force writes under each reload mode, with ticks that do and do not carry the reload event, show whether the shadow leaks early or late. Several thousand random cycles then mix ticks, events, control words, writes and reload modes against a bench model, which catches interactions that the directed cases miss.

// File: rtl/pwm_aq_pkg.sv
`timescale 1ns/1ps
package pwm_aq_pkg;

  localparam int NUM_CH  = 2;
  localparam int FIELD_W = 2;

  localparam int ZERO_LSB = 0;
  localparam int PRD_LSB  = 2;
  localparam int CMPA_LSB = 4;
  localparam int CMPB_LSB = 8;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'b00,
    ACT_LOW    = 2'b01,
    ACT_HIGH   = 2'b10,
    ACT_TOGGLE = 2'b11
  } aq_act_e;

  typedef enum logic [1:0] {
    FRC_OFF    = 2'b00,
    FRC_LOW    = 2'b01,
    FRC_HIGH   = 2'b10,
    FRC_OFF_B  = 2'b11
  } aq_frc_e;

  typedef enum logic [1:0] {
    RLD_ZERO   = 2'b00,
    RLD_PERIOD = 2'b01,
    RLD_EITHER = 2'b10,
    RLD_NOW    = 2'b11
  } aq_rld_e;

  typedef struct packed {
    logic cmpb;
    logic cmpa;
    logic period;
    logic zero;
  } aq_evt_t;

endpackage

// File: rtl/pwm_aq_force_ctl.sv
`timescale 1ns/1ps
module pwm_aq_force_ctl
  import pwm_aq_pkg::*;
#(
  parameter int CH = NUM_CH
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              evt_zero,
  input  logic              evt_period,
  input  logic              wr_en,
  input  logic [2*CH-1:0]   wr_val,
  input  logic [1:0]        reload_sel,
  output logic [2*CH-1:0]   shadow_o,
  output logic [2*CH-1:0]   active_o,
  output logic [2*CH-1:0]   effective_o
);

  localparam int VW = 2 * CH;

  logic [VW-1:0] shadow_q;
  logic [VW-1:0] active_q;
  logic          reload_now;
  aq_rld_e       sel;

  assign sel = aq_rld_e'(reload_sel);

  // Reload point decode: only a tick can move the shadow forward.
  always_comb begin
    reload_now = 1'b0;
    if (tick) begin
      unique case (sel)
        RLD_ZERO:   reload_now = evt_zero;
        RLD_PERIOD: reload_now = evt_period;
        RLD_EITHER: reload_now = evt_zero | evt_period;
        RLD_NOW:    reload_now = 1'b1;
        default:    reload_now = 1'b0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
    end else if (wr_en) begin
      shadow_q <= wr_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= '0;
    end else if (reload_now) begin
      active_q <= shadow_q;
    end
  end

  // The value being loaded on this tick already steers this tick's output.
  assign effective_o = reload_now ? shadow_q : active_q;
  assign shadow_o    = shadow_q;
  assign active_o    = active_q;

endmodule

// File: rtl/pwm_aq_event_resolve.sv
`timescale 1ns/1ps
module pwm_aq_event_resolve
  import pwm_aq_pkg::*;
#(
  parameter int CTRL_W = 16
) (
  input  logic [CTRL_W-1:0] ctl,
  input  aq_evt_t           evt,
  output aq_act_e           act
);

  aq_act_e f_zero, f_prd, f_cmpa, f_cmpb;

  assign f_zero = aq_act_e'(ctl[ZERO_LSB +: FIELD_W]);
  assign f_prd  = aq_act_e'(ctl[PRD_LSB  +: FIELD_W]);
  assign f_cmpa = aq_act_e'(ctl[CMPA_LSB +: FIELD_W]);
  assign f_cmpb = aq_act_e'(ctl[CMPB_LSB +: FIELD_W]);

  // Highest-priority event that requests something wins.
  always_comb begin
    act = ACT_NONE;
    if (evt.cmpb && f_cmpb != ACT_NONE) begin
      act = f_cmpb;
    end else if (evt.cmpa && f_cmpa != ACT_NONE) begin
      act = f_cmpa;
    end else if (evt.period && f_prd != ACT_NONE) begin
      act = f_prd;
    end else if (evt.zero && f_zero != ACT_NONE) begin
      act = f_zero;
    end
  end

endmodule

// File: rtl/pwm_aq_out_stage.sv
`timescale 1ns/1ps
module pwm_aq_out_stage
  import pwm_aq_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  logic    tick,
  input  aq_act_e act,
  input  aq_frc_e frc,
  output logic    pin
);

  logic pin_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q <= 1'b0;
    end else if (tick) begin
      unique case (frc)
        FRC_LOW:  pin_q <= 1'b0;
        FRC_HIGH: pin_q <= 1'b1;
        default: begin
          unique case (act)
            ACT_LOW:    pin_q <= 1'b0;
            ACT_HIGH:   pin_q <= 1'b1;
            ACT_TOGGLE: pin_q <= ~pin_q;
            default:    pin_q <= pin_q;
          endcase
        end
      endcase
    end
  end

  assign pin = pin_q;

endmodule

// File: rtl/pwm_aq_dual.sv
`timescale 1ns/1ps
module pwm_aq_dual
  import pwm_aq_pkg::*;
#(
  parameter int CTRL_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              evt_zero,
  input  logic              evt_period,
  input  logic              evt_cmpa_up,
  input  logic              evt_cmpb_up,
  input  logic [CTRL_W-1:0] ctl_a,
  input  logic [CTRL_W-1:0] ctl_b,
  input  logic              frc_wr,
  input  logic [3:0]        frc_val,
  input  logic [1:0]        frc_reload,
  output logic              out_a,
  output logic              out_b
);

  localparam int FW = FIELD_W * NUM_CH;

  aq_evt_t           evt;
  logic [FW-1:0]     shd_frc;
  logic [FW-1:0]     act_frc;
  logic [FW-1:0]     eff_frc;
  logic [CTRL_W-1:0] ctl_arr [NUM_CH];
  logic [NUM_CH-1:0] pins;

  assign evt.zero   = evt_zero;
  assign evt.period = evt_period;
  assign evt.cmpa   = evt_cmpa_up;
  assign evt.cmpb   = evt_cmpb_up;

  assign ctl_arr[0] = ctl_a;
  assign ctl_arr[1] = ctl_b;

  pwm_aq_force_ctl #(.CH(NUM_CH)) u_force (
    .clk         (clk),
    .rst         (rst),
    .tick        (tick),
    .evt_zero    (evt_zero),
    .evt_period  (evt_period),
    .wr_en       (frc_wr),
    .wr_val      (frc_val),
    .reload_sel  (frc_reload),
    .shadow_o    (shd_frc),
    .active_o    (act_frc),
    .effective_o (eff_frc)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    aq_act_e act;

    pwm_aq_event_resolve #(.CTRL_W(CTRL_W)) u_res (
      .ctl (ctl_arr[ch]),
      .evt (evt),
      .act (act)
    );

    pwm_aq_out_stage u_out (
      .clk  (clk),
      .rst  (rst),
      .tick (tick),
      .act  (act),
      .frc  (aq_frc_e'(eff_frc[ch*FIELD_W +: FIELD_W])),
      .pin  (pins[ch])
    );
  end

  assign out_a = pins[0];
  assign out_b = pins[1];

endmodule

// File: rtl/pwm_aq_dual_chk.sv
`timescale 1ns/1ps
module pwm_aq_dual_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic [1:0] frc_reload,
  input logic [3:0] shd_frc,
  input logic [3:0] act_frc,
  input logic [3:0] eff_frc,
  input logic       out_a,
  input logic       out_b
);

  // R1: reset clears pins and force registers
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!out_a && !out_b && act_frc == 4'd0 && shd_frc == 4'd0));

  // R3: no tick, no pin change
  p_idle_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(out_a) && $stable(out_b)));

  // R6: forced low on channel A wins over actions
  p_force_low_a_r6: assert property (@(posedge clk) disable iff (rst)
    (tick && eff_frc[1:0] == 2'b01) |=> !out_a);

  // R6: forced high on channel B wins over actions
  p_force_high_b_r6: assert property (@(posedge clk) disable iff (rst)
    (tick && eff_frc[3:2] == 2'b10) |=> out_b);

  // R7: the active force only moves on a tick
  p_active_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(act_frc));

  // R9: immediate mode copies the shadow on every tick
  p_imm_reload_r9: assert property (@(posedge clk) disable iff (rst)
    (tick && frc_reload == 2'b11) |=> (act_frc == $past(shd_frc)));

endmodule

bind pwm_aq_dual pwm_aq_dual_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .tick       (tick),
  .frc_reload (frc_reload),
  .shd_frc    (shd_frc),
  .act_frc    (act_frc),
  .eff_frc    (eff_frc),
  .out_a      (out_a),
  .out_b      (out_b)
);

// File: tb/pwm_aq_dual_test.sv
`timescale 1ns/1ps
module pwm_aq_dual_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        ez = 1'b0, ep = 1'b0, eca = 1'b0, ecb = 1'b0;
  logic [15:0] ctl_a = '0, ctl_b = '0;
  logic        frc_wr = 1'b0;
  logic [3:0]  frc_val = '0;
  logic [1:0]  frc_reload = '0;
  logic        out_a, out_b;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model state
  logic [3:0] m_shd = '0, m_act = '0;
  logic       m_a = 1'b0, m_b = 1'b0;

  always #4 clk = ~clk;

  pwm_aq_dual #(.CTRL_W(16)) uut (
    .clk(clk), .rst(rst), .tick(tick),
    .evt_zero(ez), .evt_period(ep), .evt_cmpa_up(eca), .evt_cmpb_up(ecb),
    .ctl_a(ctl_a), .ctl_b(ctl_b),
    .frc_wr(frc_wr), .frc_val(frc_val), .frc_reload(frc_reload),
    .out_a(out_a), .out_b(out_b)
  );

  function automatic logic [1:0] fld(logic [15:0] w, int lsb);
    return w[lsb +: 2];
  endfunction

  function automatic logic nxt(logic cur, logic [15:0] w, logic [1:0] f,
                               logic z, logic p, logic a, logic b);
    logic [1:0] code;
    if (f == 2'b01) return 1'b0;
    if (f == 2'b10) return 1'b1;
    code = 2'b00;
    if (z && fld(w, 0) != 2'b00) code = fld(w, 0);
    if (p && fld(w, 2) != 2'b00) code = fld(w, 2);
    if (a && fld(w, 4) != 2'b00) code = fld(w, 4);
    if (b && fld(w, 8) != 2'b00) code = fld(w, 8);
    case (code)
      2'b01:   return 1'b0;
      2'b10:   return 1'b1;
      2'b11:   return ~cur;
      default: return cur;
    endcase
  endfunction

  task automatic chk(string tag, logic ea, logic eb);
    checks++;
    if (out_a !== ea || out_b !== eb) begin
      errors++;
      $display("FAIL %s out_a=%b out_b=%b expected %b %b", tag, out_a, out_b, ea, eb);
    end
  endtask

  // Called at a falling edge: drive inputs, advance the model, check at next falling edge.
  task automatic step(string tag, logic tk, logic z, logic p, logic a, logic b,
                      logic wr, logic [3:0] fv, logic [1:0] rs);
    logic ld;
    logic [3:0] eff;
    tick = tk; ez = z; ep = p; eca = a; ecb = b;
    frc_wr = wr; frc_val = fv; frc_reload = rs;
    ld = tk && (rs == 2'b11 || (rs == 2'b00 && z) || (rs == 2'b01 && p) ||
                (rs == 2'b10 && (z || p)));
    eff = ld ? m_shd : m_act;
    if (tk) begin
      m_a = nxt(m_a, ctl_a, eff[1:0], z, p, a, b);
      m_b = nxt(m_b, ctl_b, eff[3:2], z, p, a, b);
    end
    if (ld) m_act = m_shd;
    if (wr) m_shd = fv;
    @(negedge clk);
    chk(tag, m_a, m_b);
  endtask

  task automatic idle(string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 4'd0, frc_reload);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk("R1", 1'b0, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", 1'b0, 1'b0);

    // R1: force registers start at no-force: a zero event drives high
    ctl_a = 16'h0002; ctl_b = 16'h0002;
    step("R1", 1, 1, 0, 0, 0, 0, 4'd0, 2'b00);

    // R10: normal polarity on A (zero/period high, cmpA low), inverted on B (cmpB high)
    ctl_a = 16'h001A; ctl_b = 16'h0205;
    step("R10", 1, 1, 0, 0, 0, 0, 4'd0, 2'b00);
    if (out_a !== 1'b1 || out_b !== 1'b0) begin errors++; $display("FAIL R10 zero levels %b %b expected 1 0", out_a, out_b); end
    checks++;
    step("R10", 1, 0, 0, 1, 0, 0, 4'd0, 2'b00);
    step("R10", 1, 0, 0, 0, 1, 0, 4'd0, 2'b00);
    if (out_a !== 1'b0 || out_b !== 1'b1) begin errors++; $display("FAIL R10 compare levels %b %b expected 0 1", out_a, out_b); end
    checks++;
    step("R10", 1, 0, 1, 0, 0, 0, 4'd0, 2'b00);

    // R3: strobes without tick do nothing
    step("R3", 0, 1, 1, 1, 1, 0, 4'd0, 2'b00);
    step("R3", 0, 0, 0, 1, 1, 0, 4'd0, 2'b00);

    // R2: toggle codes; R11: B has only a zero field set high
    ctl_a = 16'h0333; ctl_b = 16'h0002;
    step("R2", 1, 1, 0, 0, 0, 0, 4'd0, 2'b00);
    step("R2", 1, 0, 1, 0, 0, 0, 4'd0, 2'b00);
    step("R11", 1, 0, 0, 0, 1, 0, 4'd0, 2'b00);

    // R4: priority cmpB > cmpA > period > zero; B has cmpB=00 so zero must act
    ctl_a = 16'h0126; ctl_b = 16'h0001;
    step("R4", 1, 1, 0, 0, 0, 0, 4'd0, 2'b00);
    step("R4", 1, 1, 1, 1, 1, 0, 4'd0, 2'b00);
    step("R4", 1, 1, 1, 1, 0, 0, 4'd0, 2'b00);
    step("R4", 1, 1, 1, 0, 0, 0, 4'd0, 2'b00);

    // R5: output holds until the edge that samples the tick
    ctl_a = 16'h0002; ctl_b = 16'h0002;
    tick = 1; ez = 1; ep = 0; eca = 0; ecb = 0; frc_wr = 0;
    #1;
    chk("R5", m_a, m_b);
    step("R5", 1, 1, 0, 0, 0, 0, 4'd0, 2'b00);

    // R7/R8: shadow written with force low on A, high on B, reload at zero
    ctl_a = 16'h0002; ctl_b = 16'h0001;
    step("R7", 0, 0, 0, 0, 0, 1, 4'b1001, 2'b00);
    step("R7", 1, 0, 1, 0, 0, 0, 4'd0, 2'b00);
    step("R8", 1, 1, 0, 0, 0, 0, 4'd0, 2'b00);
    step("R6", 1, 1, 0, 0, 0, 0, 4'd0, 2'b00);
    // release via code 11, reload on period
    step("R6", 0, 0, 0, 0, 0, 1, 4'b1111, 2'b01);
    step("R8", 1, 1, 0, 0, 0, 0, 4'd0, 2'b01);
    step("R8", 1, 0, 1, 0, 0, 0, 4'd0, 2'b01);
    step("R8", 1, 1, 0, 0, 0, 0, 4'd0, 2'b10);

    // R9: immediate mode
    step("R9", 0, 0, 0, 0, 0, 1, 4'b0110, 2'b11);
    step("R9", 1, 0, 0, 0, 0, 0, 4'd0, 2'b11);
    step("R9", 1, 0, 0, 0, 0, 1, 4'b0000, 2'b11);
    step("R9", 1, 1, 0, 0, 0, 0, 4'd0, 2'b11);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      logic [3:0] ev;
      logic tk, wr;
      if ($urandom_range(0, 31) == 0) ctl_a = 16'($urandom);
      if ($urandom_range(0, 31) == 0) ctl_b = 16'($urandom);
      ev = 4'($urandom) & 4'($urandom);
      tk = ($urandom_range(0, 3) != 0);
      wr = ($urandom_range(0, 7) == 0);
      step("R6", tk, ev[0], ev[1], ev[2], ev[3], wr, 4'($urandom),
           ($urandom_range(0, 15) == 0) ? 2'($urandom) : frc_reload);
    end

    idle("R3");
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule